// File: doc/BRIEF.md
# Multi-Pattern Shift-Or String Matcher

This block scans a byte stream for several fixed strings at once. On each clock a byte may be offered with a valid strobe. A single symbol encoder reduces the byte to a short code. Every byte that appears in the configured alphabet gets its own code, and every other byte gets one shared "foreign" code. A single mismatch-mask encoder expands that code into one mask bit per pattern position. Each bit is set when the position holds a different character, and every bit is set for the foreign code.

Each pattern has its own lane. A lane holds a vector of "prefix not yet matched" flags and advances it with the shift-or rule: flag i becomes 0 only if flag i-1 was 0 and the byte equals pattern character i. Patterns, their lengths and the alphabet are elaboration-time parameters, so the whole table turns into gates and no memory is inferred. The encoder width follows the alphabet size as clog2(symbols+2).

The default configuration uses three patterns over the alphabet {a,b,c,d}: "aadc" (lane 0), "bdb" (lane 1) and "adc" (lane 2).

Top module: `smatch_multi`

## Requirements
- R1: A synchronous active-high reset clears all partial-match progress and drives every bit of match_o to 0. Bytes accepted before the reset cannot contribute to a match after it.
- R2: match_o[p] is 1 for exactly the one cycle that follows the clock edge at which the valid byte completing pattern p was accepted. In every other cycle it is 0.
- R3: Cycles with in_valid low are ignored. Lane state is held, match_o is 0 during the following cycle, and a pattern whose bytes are separated by idle cycles still matches.
- R4: Overlapping occurrences are each reported. In the stream "bdbdb", pattern "bdb" (lane 1) flags after the 3rd and after the 5th byte.
- R5: Several lanes can flag on the same cycle. The stream "aadc" sets bit 0 ("aadc") and bit 2 ("adc") together.
- R6: A byte outside the alphabet (for example "x") breaks every partial match. "aaxdc" produces no match on any lane.
- R7: Each lane honours its own length, 4 for lane 0 and 3 for lanes 1 and 2. A lane flags only when its last LEN accepted bytes equal its pattern.
- R8: A failed partial match does not hide a later occurrence that starts inside it. "aaadc" flags lane 0 after the 5th byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The byte on in_char is accepted this cycle |
| in_char | input | 8 | Input byte |
| match_o | output | NPAT | One registered match pulse per pattern, bit p for pattern p |

## Verification
The assertions check four properties on every cycle:
- Lane state stays unchanged through idle cycles.
- A match pulse only follows an accepted byte, and that byte equals the last character of the pattern.
- An unmatched prefix of length i-1 forces prefix i to be unmatched on the next beat.
- A foreign byte leaves every match bit at 0.

Whether a pulse marks a real occurrence can only be shown by the bench's scenarios. The bench compares the output against a history of the accepted bytes. That covers overlapping hits, simultaneous hits, restarts after a partial match, and reset wiping prefixes seen earlier. It sweeps every four-byte word over the alphabet plus a foreign byte, then runs a long pseudo-random stream with idle gaps.

// File: rtl/smatch_pkg.sv
package smatch_pkg;

    typedef logic [7:0] char_t;

    // one offered beat at the block input
    typedef struct packed {
        logic  valid;
        char_t ch;
    } beat_t;

    localparam int DEF_NPAT   = 3;
    localparam int DEF_MAXLEN = 4;
    localparam int DEF_NSYM   = 4;

    // codes 0..nsym-1 name alphabet symbols, nsym is the foreign code,
    // nsym+1 is reserved for pattern bytes missing from the alphabet
    function automatic int code_bits(input int nsym);
        return $clog2(nsym + 2);
    endfunction

endpackage

// File: rtl/sm_sym_enc.sv
module sm_sym_enc
    import smatch_pkg::*;
#(
    parameter int NSYM = DEF_NSYM,
    parameter int CW   = code_bits(DEF_NSYM),
    parameter logic [NSYM-1:0][7:0] ALPHABET = "dcba"
) (
    input  char_t         ch,
    output logic [CW-1:0] code
);

    logic [NSYM-1:0] hit;

    for (genvar k = 0; k < NSYM; k++) begin : g_cmp
        assign hit[k] = (ch == ALPHABET[k]);
    end

    always_comb begin
        code = CW'(NSYM);
        for (int k = NSYM - 1; k >= 0; k--) begin
            if (hit[k]) code = CW'(k);
        end
    end

endmodule

// File: rtl/sm_bitmap_enc.sv
module sm_bitmap_enc
    import smatch_pkg::*;
#(
    parameter int NPAT   = DEF_NPAT,
    parameter int MAXLEN = DEF_MAXLEN,
    parameter int NSYM   = DEF_NSYM,
    parameter int CW     = code_bits(DEF_NSYM),
    parameter logic [NSYM-1:0][7:0] ALPHABET = "dcba",
    parameter logic [NPAT-1:0][MAXLEN-1:0][7:0] PATTERNS =
        {8'h00, "cda", 8'h00, "bdb", "cdaa"}
) (
    input  logic [CW-1:0]                code,
    output logic [NPAT-1:0][MAXLEN-1:0]  mism
);

    // symbol index of a constant pattern byte; NSYM+1 if absent
    function automatic int sym_of(input char_t c);
        int r;
        r = NSYM + 1;
        for (int k = NSYM - 1; k >= 0; k--) begin
            if (ALPHABET[k] == c) r = k;
        end
        return r;
    endfunction

    for (genvar p = 0; p < NPAT; p++) begin : g_pat
        for (genvar i = 0; i < MAXLEN; i++) begin : g_pos
            localparam int IDX = sym_of(PATTERNS[p][i]);
            assign mism[p][i] = (code != CW'(IDX));
        end
    end

endmodule

// File: rtl/sm_lane.sv
module sm_lane #(
    parameter int LEN = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           valid,
    input  logic [LEN-1:0] mism,
    output logic           match
);

    // st[i] == 0 : the first i+1 pattern bytes equal the last i+1 accepted bytes
    logic [LEN-1:0] st;
    logic [LEN-1:0] st_n;

    always_comb begin
        st_n[0] = mism[0];
        for (int i = 1; i < LEN; i++) begin
            st_n[i] = st[i-1] | mism[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '1;
            match <= 1'b0;
        end else begin
            if (valid) st <= st_n;
            match <= valid & ~st_n[LEN-1];
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (st == '1) && !match);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(st) && !match);

    // R2
    match_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
        match |-> $past(valid));

    for (genvar i = 1; i < LEN; i++) begin : g_chain
        // R8
        prefix_chain_chk: assert property (@(posedge clk) disable iff (rst)
            (valid && st[i-1]) |=> st[i]);
    end

endmodule

// File: rtl/smatch_multi.sv
module smatch_multi
    import smatch_pkg::*;
#(
    parameter int NPAT   = DEF_NPAT,
    parameter int MAXLEN = DEF_MAXLEN,
    parameter int NSYM   = DEF_NSYM,
    parameter logic [NSYM-1:0][7:0] ALPHABET = "dcba",
    parameter logic [NPAT-1:0][MAXLEN-1:0][7:0] PATTERNS =
        {8'h00, "cda", 8'h00, "bdb", "cdaa"},
    parameter logic [NPAT-1:0][7:0] PAT_LEN = {8'd3, 8'd3, 8'd4}
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [7:0]      in_char,
    output logic [NPAT-1:0] match_o
);

    localparam int CW = code_bits(NSYM);

    beat_t                       beat;
    logic [CW-1:0]               code;
    logic [NPAT-1:0][MAXLEN-1:0] mism;

    assign beat = '{valid: in_valid, ch: in_char};

    sm_sym_enc #(
        .NSYM     (NSYM),
        .CW       (CW),
        .ALPHABET (ALPHABET)
    ) u_sym (
        .ch   (beat.ch),
        .code (code)
    );

    sm_bitmap_enc #(
        .NPAT     (NPAT),
        .MAXLEN   (MAXLEN),
        .NSYM     (NSYM),
        .CW       (CW),
        .ALPHABET (ALPHABET),
        .PATTERNS (PATTERNS)
    ) u_bmp (
        .code (code),
        .mism (mism)
    );

    for (genvar g = 0; g < NPAT; g++) begin : g_lane
        localparam int L = int'(PAT_LEN[g]);

        sm_lane #(.LEN(L)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .valid (beat.valid),
            .mism  (mism[g][L-1:0]),
            .match (match_o[g])
        );

        // R2
        tail_char_chk: assert property (@(posedge clk) disable iff (rst)
            match_o[g] |-> ($past(in_char) == PATTERNS[g][L-1]));
    end

    // R6
    foreign_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && code == CW'(NSYM)) |=> (match_o == '0));

endmodule

// File: tb/smatch_multi_tb.sv
`timescale 1ns/1ps
module smatch_multi_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_char = 8'h00;
    logic [2:0] match_o;

    int total = 0;
    int bad   = 0;

    string pats [3] = '{"aadc", "bdb", "adc"};
    string syms     = "abcdx";

    logic [7:0] h [4];
    int         nval = 0;

    always #5 clk = ~clk;

    smatch_multi u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_char  (in_char),
        .match_o  (match_o)
    );

    function automatic bit hit(input int p);
        int L;
        L = pats[p].len();
        if (nval < L) return 1'b0;
        for (int j = 0; j < L; j++) begin
            if (h[L-1-j] != pats[p][j]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: match_o=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        nval = 0;
        check("R1 reset state", match_o, 3'b000);
    endtask

    task automatic push(input bit v, input logic [7:0] c, input string tag);
        logic [2:0] exp;
        in_valid = v;
        in_char  = c;
        if (v) begin
            h[3] = h[2]; h[2] = h[1]; h[1] = h[0]; h[0] = c;
            nval++;
        end
        for (int p = 0; p < 3; p++) exp[p] = v ? hit(p) : 1'b0;
        @(negedge clk);
        check(tag, match_o, exp);
    endtask

    task automatic push_str(input string s, input string tag);
        for (int k = 0; k < s.len(); k++) push(1'b1, s[k], tag);
        push(1'b0, 8'h00, tag);
    endtask

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        do_reset();

        // R1: prefix seen before reset must not complete afterwards
        push(1'b1, "a", "R1");
        push(1'b1, "a", "R1");
        do_reset();
        push(1'b1, "d", "R1");
        push(1'b1, "c", "R1 no match after reset");

        // R3: idle gaps inside an occurrence
        do_reset();
        push(1'b1, "a", "R3");
        push(1'b0, "c", "R3 idle");
        push(1'b1, "a", "R3");
        push(1'b0, "d", "R3 idle");
        push(1'b0, "b", "R3 idle");
        push(1'b1, "d", "R3");
        push(1'b0, "c", "R3 idle");
        push(1'b1, "c", "R3 match across gaps");
        push(1'b0, "c", "R3 idle after match");

        do_reset();
        push_str("bdbdb", "R4 overlap");
        do_reset();
        push_str("aadc", "R5 simultaneous");
        do_reset();
        push_str("aaxdc", "R6 foreign byte");
        do_reset();
        push_str("aaadc", "R8 restart");

        // R2 R7: every four-byte word over the alphabet plus a foreign byte
        for (int w = 0; w < 625; w++) begin
            do_reset();
            push(1'b1, syms[w % 5],        "R2 R7 sweep");
            push(1'b1, syms[(w / 5) % 5],   "R2 R7 sweep");
            push(1'b1, syms[(w / 25) % 5],  "R2 R7 sweep");
            push(1'b1, syms[(w / 125) % 5], "R2 R7 sweep");
            push(1'b0, 8'h00,               "R2 R7 sweep");
        end

        // R2 R3 R4: long stream with idle gaps
        do_reset();
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            push(lfsr[7:5] != 3'd0, syms[lfsr[3:0] % 5], "R2 R3 stream");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule